// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits on the controller side of a 16-bit mobile SDRAM and owns the command pins whenever the memory needs refreshing or is being put to sleep. A host timer pulses a refresh-due input. The host may also ask for self refresh (sleep), ask for deep power down (deep sleep), or ask to wake. A status input tells the block whether every bank is idle. The block turns these requests into chip-select, row/column strobe, write-enable, clock-enable and byte-mask levels on the pins.

After each auto refresh, and after the device leaves self refresh, the block waits out the row-cycle time before it issues anything else. Leaving deep power down loses the device state. In that case the block raises a re-initialization flag and withholds normal access until the host acknowledges that initialization is done. On every cycle where no command is issued, chip select is held high (deselect).

Top module: `sdram_pwr_seq`

## Requirements
- R1: During and directly after reset, the pins show deselect (cs_n, ras_n, cas_n, we_n all 1), cke is 1, dqm is 2'b00, access_ok is 1 and need_init is 0.
- R2: An auto refresh is driven as cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1. It appears in the cycle after a clock edge at which a refresh is due and banks_idle is 1.
- R3: A refresh tick that arrives while banks_idle is 0 is held. No command is driven until banks_idle is seen high, and the refresh then appears in the following cycle.
- R4: A pending refresh is issued before a sleep or deep-sleep request that is waiting at the same time.
- R5: No command is driven earlier than TRC cycles after an auto refresh, or after the cycle in which cke returns high. A request that is already waiting is issued exactly TRC cycles later.
- R6: Self refresh entry is driven as cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=0. It is issued only when banks_idle is 1.
- R7: While cke stays low, every cycle after the entry command is a deselect, dqm is 2'b11, access_ok is 0, and refresh, sleep and deep-sleep requests have no effect.
- R8: A wake request in self refresh raises cke in the next cycle, with dqm back to 2'b00.
- R9: Deep power down entry is driven as cs_n=0, ras_n=1, cas_n=1, we_n=0 with cke=0. It takes precedence over a sleep request arriving at the same time, and is issued only when banks_idle is 1.
- R10: A wake request in deep power down raises cke and need_init in the next cycle. need_init then stays high, access_ok stays low and only deselects are driven until an init_ack is accepted. An init_ack is accepted no earlier than TRC-1 cycles after cke rises. Refresh ticks seen meanwhile are discarded.
- R11: Only auto refresh, self refresh entry and deep power down entry are ever driven as commands. All other cycles are deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Refresh-due pulse from the host timer |
| sleep_req | input | 1 | Request to enter self refresh |
| deep_req | input | 1 | Request to enter deep power down |
| wake_req | input | 1 | Request to leave the current low-power mode |
| banks_idle | input | 1 | All banks are precharged and idle |
| init_ack | input | 1 | Host has completed full initialization |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 2 | Byte-lane masks, upper lane in bit 1 |
| access_ok | output | 1 | Normal commands may be issued |
| need_init | output | 1 | Full re-initialization required |

## Verification
Directed sequences first check the exact cycle positions of the commands. One places a sleep request behind a refresh, which separates a correct row-cycle wait from one that is off by a cycle. Another holds a tick while the banks are busy with sleep also pending, which tells priority apart from first-come ordering. Others drive refresh and sleep requests inside each low-power mode, which exposes any input that leaks through. A seeded random phase then mixes busy banks, ticks, sleep, deep-sleep, wake and acknowledge at varied densities. Every cycle is checked against bench functions for legal encodings, spacing against the last command or cke rise, the idle condition at the deciding edge, and the mask and flag levels.

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq #(
  parameter int TRC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       sleep_req,
  input  logic       deep_req,
  input  logic       wake_req,
  input  logic       banks_idle,
  input  logic       init_ack,
  output logic       sd_cs_n,
  output logic       sd_ras_n,
  output logic       sd_cas_n,
  output logic       sd_we_n,
  output logic       sd_cke,
  output logic [1:0] sd_dqm,
  output logic       access_ok,
  output logic       need_init
);

  localparam int CW = $clog2(TRC + 1);
  localparam logic [CW-1:0] WAIT_LD = CW'(TRC - 2);

  localparam logic [3:0] C_DSEL = 4'b1111;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_DPD  = 4'b0110;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SELF, S_DEEP, S_INIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          ref_pend;
  logic [3:0]    cmd;

  wire due = ref_pend | ref_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ref_pend  <= 1'b0;
      cmd       <= C_DSEL;
      sd_cke    <= 1'b1;
      sd_dqm    <= 2'b00;
      need_init <= 1'b0;
    end else begin
      cmd <= C_DSEL;
      case (st)
        S_IDLE: begin
          if (due && banks_idle) begin
            cmd      <= C_REF;
            ref_pend <= 1'b0;
            cnt      <= WAIT_LD;
            st       <= S_WAIT;
          end else if (due) begin
            ref_pend <= 1'b1;
          end else if (deep_req && banks_idle) begin
            cmd    <= C_DPD;
            sd_cke <= 1'b0;
            sd_dqm <= 2'b11;
            st     <= S_DEEP;
          end else if (sleep_req && banks_idle) begin
            cmd    <= C_REF;
            sd_cke <= 1'b0;
            sd_dqm <= 2'b11;
            st     <= S_SELF;
          end
        end
        S_WAIT: begin
          if (ref_tick) ref_pend <= 1'b1;
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        S_SELF: begin
          if (wake_req) begin
            sd_cke <= 1'b1;
            sd_dqm <= 2'b00;
            cnt    <= WAIT_LD;
            st     <= S_WAIT;
          end
        end
        S_DEEP: begin
          if (wake_req) begin
            sd_cke    <= 1'b1;
            sd_dqm    <= 2'b00;
            need_init <= 1'b1;
            cnt       <= WAIT_LD;
            st        <= S_INIT;
          end
        end
        S_INIT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (init_ack) begin
            need_init <= 1'b0;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign access_ok = (st == S_IDLE);

endmodule

// File: rtl/sdram_pwr_seq_chk.sv
module sdram_pwr_seq_chk #(
  parameter int TRC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       banks_idle,
  input logic       sd_cs_n,
  input logic       sd_cke,
  input logic [1:0] sd_dqm,
  input logic       access_ok,
  input logic       need_init
);

  int   gap;
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= TRC;
      cke_q <= 1'b1;
    end else begin
      cke_q <= sd_cke;
      if (!sd_cs_n || (sd_cke && !cke_q)) gap <= 1;
      else if (gap < TRC)                 gap <= gap + 1;
    end
  end

  // R5
  trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> gap >= TRC);

  // R6
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> $past(banks_idle));

  // R7
  lp_dsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cke && !cke_q) |-> sd_cs_n);

  // R7
  lp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> (sd_dqm == 2'b11 && !access_ok));

  // R8
  wake_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cke && !cke_q) |-> sd_dqm == 2'b00);

  // R10
  init_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    need_init |-> (!access_ok && sd_cs_n));

endmodule

bind sdram_pwr_seq sdram_pwr_seq_chk #(.TRC(TRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sd_cs_n(sd_cs_n),
  .sd_cke(sd_cke), .sd_dqm(sd_dqm), .access_ok(access_ok), .need_init(need_init)
);

// File: tb/sdram_pwr_seq_tb.sv
module sdram_pwr_seq_tb;
  localparam int TRC = 6;
  localparam logic [4:0] P_REF  = 5'b00011;
  localparam logic [4:0] P_SELF = 5'b00010;
  localparam logic [4:0] P_DPD  = 5'b01100;
  localparam logic [4:0] P_DSH  = 5'b11111;
  localparam logic [4:0] P_DSL  = 5'b11110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ref_tick, sleep_req, deep_req, wake_req, banks_idle, init_ack;
  logic cs_n, ras_n, cas_n, we_n, cke, access_ok, need_init;
  logic [1:0] dqm;
  int total = 0, bad = 0;

  sdram_pwr_seq #(.TRC(TRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sleep_req(sleep_req),
    .deep_req(deep_req), .wake_req(wake_req), .banks_idle(banks_idle),
    .init_ack(init_ack), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_cke(cke), .sd_dqm(dqm), .access_ok(access_ok),
    .need_init(need_init)
  );

  function automatic logic [4:0] pins();
    return {cs_n, ras_n, cas_n, we_n, cke};
  endfunction

  function automatic bit legal_cmd(logic [4:0] p);
    return (p == P_REF) || (p == P_SELF) || (p == P_DPD);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic pin_is(logic [4:0] e, string req);
    chk(pins() == e, req, "pins", int'(pins()), int'(e));
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap;
    logic prev_idle, prev_cke;
    void'($urandom(32'd1234));
    rst_n = 0; ref_tick = 0; sleep_req = 0; deep_req = 0; wake_req = 0;
    banks_idle = 1; init_ack = 0;
    repeat (3) cyc();
    pin_is(P_DSH, "R1");
    rst_n = 1;
    cyc();
    pin_is(P_DSH, "R1");
    chk(dqm == 2'b00 && access_ok && !need_init, "R1", "flags",
        {dqm, access_ok, need_init}, 4'b0010);

    // refresh then sleep waiting behind it
    ref_tick = 1; cyc(); ref_tick = 0;
    pin_is(P_REF, "R2");
    chk(!access_ok, "R5", "access_ok", access_ok, 0);
    sleep_req = 1;
    for (int i = 1; i < TRC; i++) begin cyc(); pin_is(P_DSH, "R5"); end
    cyc(); pin_is(P_SELF, "R6");
    chk(dqm == 2'b11, "R7", "dqm", dqm, 3);
    ref_tick = 1; deep_req = 1;
    repeat (4) begin
      cyc(); pin_is(P_DSL, "R7");
      chk(dqm == 2'b11 && !access_ok, "R7", "mask", {dqm, access_ok}, 6);
    end
    ref_tick = 0; deep_req = 0; sleep_req = 0;
    wake_req = 1; cyc(); wake_req = 0;
    pin_is(P_DSH, "R8");
    chk(dqm == 2'b00, "R8", "dqm", dqm, 0);
    ref_tick = 1;
    for (int i = 1; i < TRC; i++) begin cyc(); ref_tick = 0; pin_is(P_DSH, "R5"); end
    cyc(); pin_is(P_REF, "R5");
    for (int i = 1; i < TRC; i++) begin cyc(); pin_is(P_DSH, "R11"); end

    // tick held while busy, refresh beats sleep
    banks_idle = 0; ref_tick = 1; sleep_req = 1;
    cyc(); ref_tick = 0;
    pin_is(P_DSH, "R3");
    repeat (4) begin cyc(); pin_is(P_DSH, "R3"); end
    banks_idle = 1;
    cyc(); pin_is(P_REF, "R4");
    for (int i = 1; i < TRC; i++) begin cyc(); pin_is(P_DSH, "R5"); end
    cyc(); pin_is(P_SELF, "R4");
    sleep_req = 0;
    wake_req = 1; cyc(); wake_req = 0;
    for (int i = 1; i < TRC; i++) cyc();

    // deep power down beats sleep, then forced init
    deep_req = 1; sleep_req = 1;
    cyc(); deep_req = 0; sleep_req = 0;
    pin_is(P_DPD, "R9");
    cyc(); pin_is(P_DSL, "R9");
    wake_req = 1; cyc(); wake_req = 0;
    pin_is(P_DSH, "R10");
    chk(need_init && !access_ok, "R10", "init flag", {need_init, access_ok}, 2);
    ref_tick = 1; sleep_req = 1;
    for (int i = 1; i < TRC; i++) begin
      cyc(); pin_is(P_DSH, "R10");
      chk(need_init && !access_ok, "R10", "init held", {need_init, access_ok}, 2);
    end
    ref_tick = 0; sleep_req = 0; init_ack = 1;
    cyc(); init_ack = 0;
    chk(!need_init && access_ok, "R10", "init done", {need_init, access_ok}, 1);
    cyc(); pin_is(P_DSH, "R10");

    // seeded random mix
    gap = TRC; prev_cke = cke;
    for (int n = 0; n < 4000; n++) begin
      banks_idle = ($urandom % 4) != 0;
      ref_tick   = ($urandom % 16) == 0;
      sleep_req  = ($urandom % 8) == 0;
      deep_req   = ($urandom % 32) == 0;
      wake_req   = ($urandom % 6) == 0;
      init_ack   = ($urandom % 5) == 0;
      prev_idle  = banks_idle;
      prev_cke   = cke;
      cyc();
      if (!cs_n) begin
        chk(legal_cmd(pins()), "R11", "encoding", int'(pins()), int'(P_REF));
        chk(gap >= TRC, "R5", "spacing", gap, TRC);
        chk(prev_idle, "R2", "idle at issue", prev_idle, 1);
      end
      if (!cke && !prev_cke) chk(cs_n, "R7", "deselect", cs_n, 1);
      if (!cke) chk(dqm == 2'b11 && !access_ok, "R7", "mask", {dqm, access_ok}, 6);
      if (need_init) chk(!access_ok && cs_n, "R10", "blocked", {access_ok, cs_n}, 1);
      if (!cs_n || (cke && !prev_cke)) gap = 1;
      else if (gap < TRC) gap++;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule